// File: doc/BRIEF.md
# Virtual Address Canonical Form Checker

This block decides whether a 64-bit virtual address is in canonical form before the address is used. An address is canonical when its upper bits are a sign extension of the highest implemented address bit. The request carries the address, a kind field and a mode field. The kind says whether the address is a data access operand, a control-transfer target (jump, call, return) or the result of a pure address computation. The mode sets the implemented width, either 48 or 57 bits. It can also relax the check for tagged pointers: in one relaxation only the top address bit is compared with the highest implemented bit, and in the other the upper bits are not checked at all.

The result appears one clock after the request and holds four items. The first is a fault flag. The second is a general-protection marker, which is set for failed control-transfer targets and means error code 0. The third is a permission flag that allows the target to be loaded as the new instruction pointer. The fourth is the untagged effective address: the upper bits are rebuilt as a copy of the highest implemented bit. The decision is a pure function of the address bits and the mode, so no translation state is consulted.

Top module: `vacc_top`

## Requirements
- R1: With req_mode = 3'b000 (narrow width, no relaxation), a data or transfer address passes only when bits 63..47 are all equal. Otherwise the request faults.
- R2: With req_mode bit 0 set (wide width), only bits 63..56 must be equal. Bits 55..47 are free, so 0x0000_8000_0000_0000 passes and 0x0100_0000_0000_0000 faults.
- R3: With req_mode bit 1 set (top-bit relaxation), a request passes exactly when bit 63 equals bit 47 (narrow) or bit 56 (wide). The bits between them are not examined.
- R4: With req_mode bit 2 set (ignore relaxation), every request passes, whatever the upper bits and whatever the state of bit 1.
- R5: A failing request of kind 2'b01 (control transfer) gives res_fault=1 and res_fault_gp=1 (error code 0), with res_ip_load=0. A passing transfer gives res_ip_load=1.
- R6: A failing request of kind 2'b00 (data access), or of kind 2'b11 (treated as a data access), gives res_fault=1, res_fault_gp=0 and res_ip_load=0.
- R7: A request of kind 2'b10 (address computation only) is never checked and always passes, with res_ip_load=0.
- R8: For a passing request, res_addr equals the request address with every bit above the highest implemented bit (47 or 56) replaced by that bit. For a faulting request, res_addr is zero.
- R9: res_valid follows req_valid by exactly one clock. When req_valid is low, the next result has every flag and res_addr at zero.
- R10: A synchronous active-high reset drives res_valid, res_fault, res_fault_gp, res_ip_load and res_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Virtual address to check |
| req_kind | input | 2 | 00 data, 01 transfer, 10 compute only, 11 data |
| req_mode | input | 3 | bit0 wide width, bit1 top-bit relaxation, bit2 ignore relaxation |
| res_valid | output | 1 | Result present |
| res_fault | output | 1 | Address is not canonical under the selected mode |
| res_fault_gp | output | 1 | General-protection fault on a transfer target, error code 0 |
| res_ip_load | output | 1 | Transfer target may become the instruction pointer |
| res_addr | output | 64 | Untagged address; zero on fault |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 48-bit narrow width and a 57-bit wide width. With these values the exact boundary words can be driven at both widths, such as 0x0000_7FFF_FFFF_FFFF against 0x0000_8000_0000_0000 and 0x00FF_FFFF_FFFF_FFFF against 0x0100_0000_0000_0000. The address 0x0000_8000_0000_0000 passes in the wide width and faults in the narrow one. Tagged pointers with junk in the middle bits exercise the two relaxations and the rebuilt upper bits. Each mode is crossed with the four request kinds.

// File: rtl/vacc_pkg.sv
package vacc_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_XFER = 2'b01,
        KIND_CALC = 2'b10,
        KIND_RSVD = 2'b11
    } req_kind_e;

    // bit 2: ignore relaxation, bit 1: top-bit relaxation, bit 0: wide width
    typedef struct packed {
        logic ign;
        logic topbit;
        logic wide;
    } mode_t;

    typedef enum logic [1:0] {
        CHK_STRICT = 2'b00,
        CHK_TOPBIT = 2'b01,
        CHK_NONE   = 2'b10
    } chk_sel_e;

    typedef struct packed {
        logic fault;
        logic gp;
        logic ip_load;
    } verdict_t;

    localparam int N_WIDTHS = 2;

    // Ignore beats top-bit relaxation; compute-only requests skip checking.
    function automatic chk_sel_e pick_check(mode_t m, req_kind_e k);
        if (k == KIND_CALC || m.ign) return CHK_NONE;
        if (m.topbit)                return CHK_TOPBIT;
        return CHK_STRICT;
    endfunction

endpackage

// File: rtl/vacc_span.sv
module vacc_span #(
    parameter int ADDR_W = 64,
    parameter int TOP    = 47
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              strict_ok,
    output logic              topbit_ok,
    output logic [ADDR_W-1:0] untag
);
    localparam int HI_N  = ADDR_W - TOP;
    localparam int EXT_N = ADDR_W - 1 - TOP;

    logic [HI_N-1:0] hi;

    always_comb begin
        hi        = addr[ADDR_W-1:TOP];
        strict_ok = (&hi) | ~(|hi);
        topbit_ok = (addr[ADDR_W-1] == addr[TOP]);
        untag     = {{EXT_N{addr[TOP]}}, addr[TOP:0]};
    end
endmodule

// File: rtl/vacc_judge.sv
module vacc_judge
    import vacc_pkg::*;
(
    input  logic [N_WIDTHS-1:0] strict_ok,
    input  logic [N_WIDTHS-1:0] topbit_ok,
    input  mode_t               mode,
    input  req_kind_e           kind,
    output verdict_t            verdict
);
    chk_sel_e sel;
    logic     pass;
    logic     w;

    always_comb begin
        w    = mode.wide;
        sel  = pick_check(mode, kind);
        unique case (sel)
            CHK_STRICT: pass = strict_ok[w];
            CHK_TOPBIT: pass = topbit_ok[w];
            default:    pass = 1'b1;
        endcase
        verdict.fault   = ~pass;
        verdict.gp      = ~pass & (kind == KIND_XFER);
        verdict.ip_load = pass & (kind == KIND_XFER);
    end
endmodule

// File: rtl/vacc_top.sv
module vacc_top
    import vacc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LOW_VA = 48,
    parameter int HIGH_VA = 57
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_mode,
    output logic              res_valid,
    output logic              res_fault,
    output logic              res_fault_gp,
    output logic              res_ip_load,
    output logic [ADDR_W-1:0] res_addr
);
    localparam int LOW_TOP  = LOW_VA - 1;
    localparam int HIGH_TOP = HIGH_VA - 1;

    logic [N_WIDTHS-1:0] strict_ok;
    logic [N_WIDTHS-1:0] topbit_ok;
    logic [ADDR_W-1:0]   untag [N_WIDTHS];
    mode_t               mode;
    req_kind_e           kind;
    verdict_t            verdict;
    logic [ADDR_W-1:0]   addr_nx;

    assign mode = mode_t'(req_mode);
    assign kind = req_kind_e'(req_kind);

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_span
        localparam int TOP = (g == 0) ? LOW_TOP : HIGH_TOP;
        vacc_span #(.ADDR_W(ADDR_W), .TOP(TOP)) span_i (
            .addr      (req_addr),
            .strict_ok (strict_ok[g]),
            .topbit_ok (topbit_ok[g]),
            .untag     (untag[g])
        );
    end

    vacc_judge judge_i (
        .strict_ok (strict_ok),
        .topbit_ok (topbit_ok),
        .mode      (mode),
        .kind      (kind),
        .verdict   (verdict)
    );

    assign addr_nx = verdict.fault ? '0 : untag[mode.wide];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_fault    <= 1'b0;
            res_fault_gp <= 1'b0;
            res_ip_load  <= 1'b0;
            res_addr     <= '0;
        end else begin
            res_valid    <= req_valid;
            res_fault    <= req_valid & verdict.fault;
            res_fault_gp <= req_valid & verdict.gp;
            res_ip_load  <= req_valid & verdict.ip_load;
            res_addr     <= req_valid ? addr_nx : '0;
        end
    end

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (res_valid == $past(req_valid)));

    // R5
    gp_blocks_ip_chk: assert property (@(posedge clk) disable iff (rst)
        res_fault_gp |-> (res_fault && !res_ip_load));

    // R7
    calc_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(req_valid) && $past(req_kind) == 2'b10) |-> !res_fault);

    // R4
    ignore_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(req_valid) && $past(req_mode[2])) |-> !res_fault);

    // R8
    untag_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && res_valid && !res_fault && !$past(req_mode[0]))
            |-> (res_addr[ADDR_W-1] == res_addr[LOW_TOP]));

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> (res_addr == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_fault || res_ip_load));
endmodule

// File: tb/vacc_top_tb_top.sv
module vacc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_mode = '0;
    logic        res_valid, res_fault, res_fault_gp, res_ip_load;
    logic [63:0] res_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vacc_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_mode(req_mode), .res_valid(res_valid),
        .res_fault(res_fault), .res_fault_gp(res_fault_gp),
        .res_ip_load(res_ip_load), .res_addr(res_addr)
    );

    function automatic bit model_ok(logic [63:0] a, logic [1:0] k, logic [2:0] m);
        int top;
        top = m[0] ? 56 : 47;
        if (k == 2'b10 || m[2]) return 1'b1;
        if (m[1]) return a[63] == a[top];
        for (int i = top + 1; i < 64; i++)
            if (a[i] != a[top]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] model_addr(logic [63:0] a, logic [2:0] m);
        logic [63:0] r;
        int top;
        top = m[0] ? 56 : 47;
        r = a;
        for (int i = top + 1; i < 64; i++) r[i] = a[top];
        return r;
    endfunction

    task automatic check(string req, logic [67:0] act, logic [67:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one request at a falling edge and checks the result one edge later.
    task automatic send(string req, logic [63:0] a, logic [1:0] k, logic [2:0] m);
        bit ok;
        logic [67:0] exp;
        req_valid = 1'b1; req_addr = a; req_kind = k; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        ok = model_ok(a, k, m);
        exp = {1'b1, !ok, !ok && k == 2'b01, ok && k == 2'b01,
               ok ? model_addr(a, m) : 64'h0};
        check(req, {res_valid, res_fault, res_fault_gp, res_ip_load, res_addr}, exp);
    endtask

    task automatic t_reset();
        check("R10", {res_valid, res_fault, res_fault_gp, res_ip_load, res_addr}, 68'h0);
    endtask

    task automatic t_narrow();
        send("R1", 64'h0000_7FFF_FFFF_FFFF, 2'b00, 3'b000);
        send("R1", 64'h0000_8000_0000_0000, 2'b00, 3'b000);
        send("R1", 64'hFFFF_8000_0000_0000, 2'b00, 3'b000);
        send("R1", 64'hFFFF_7FFF_FFFF_FFFF, 2'b00, 3'b000);
        send("R1", 64'h8000_0000_0000_0000, 2'b00, 3'b000);
    endtask

    task automatic t_wide();
        send("R2", 64'h00FF_FFFF_FFFF_FFFF, 2'b00, 3'b001);
        send("R2", 64'h0100_0000_0000_0000, 2'b00, 3'b001);
        send("R2", 64'hFF00_0000_0000_0000, 2'b00, 3'b001);
        send("R2", 64'h0000_8000_0000_0000, 2'b00, 3'b001);
        send("R2", 64'hFE00_0000_0000_0000, 2'b00, 3'b001);
    endtask

    task automatic t_topbit();
        send("R3", 64'h7A00_7FFF_FFFF_FFFF, 2'b00, 3'b010);
        send("R3", 64'h8000_0000_0000_0000, 2'b00, 3'b010);
        send("R3", 64'h8123_8000_0000_0000, 2'b00, 3'b010);
        send("R3", 64'h3C00_0000_0000_1234, 2'b00, 3'b011);
        send("R3", 64'h0100_0000_0000_0000, 2'b00, 3'b011);
    endtask

    task automatic t_ignore();
        send("R4", 64'h8000_0000_0000_0000, 2'b00, 3'b100);
        send("R4", 64'h8000_0000_0000_0000, 2'b01, 3'b110);
        send("R4", 64'h5A5A_0000_0000_0001, 2'b00, 3'b101);
    endtask

    task automatic t_xfer();
        send("R5", 64'h0000_8000_0000_0000, 2'b01, 3'b000);
        send("R5", 64'hFFFF_8000_0000_1000, 2'b01, 3'b000);
        send("R5", 64'h0100_0000_0000_0000, 2'b01, 3'b001);
    endtask

    task automatic t_data();
        send("R6", 64'h0001_0000_0000_0000, 2'b00, 3'b000);
        send("R6", 64'h0001_0000_0000_0000, 2'b11, 3'b000);
        send("R6", 64'h0000_0000_0000_4000, 2'b11, 3'b000);
    endtask

    task automatic t_calc();
        send("R7", 64'h0001_0000_0000_0000, 2'b10, 3'b000);
        send("R7", 64'h8000_0000_0000_0000, 2'b10, 3'b011);
    endtask

    task automatic t_untag();
        send("R8", 64'hAB00_4000_0000_0010, 2'b00, 3'b100);
        send("R8", 64'h1200_C000_0000_0010, 2'b01, 3'b110);
        send("R8", 64'h7F80_0000_0000_0000, 2'b00, 3'b011);
    endtask

    task automatic t_idle();
        req_valid = 1'b0; req_addr = 64'h0001_0000_0000_0000; req_kind = 2'b01;
        @(negedge clk);
        check("R9", {res_valid, res_fault, res_fault_gp, res_ip_load, res_addr}, 68'h0);
    endtask

    task automatic t_mid_reset();
        req_valid = 1'b1; req_addr = 64'h0001_0000_0000_0000; req_kind = 2'b01; req_mode = 3'b000;
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b0;
        check("R10", {res_valid, res_fault, res_fault_gp, res_ip_load, res_addr}, 68'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_narrow();
        t_wide();
        t_topbit();
        t_ignore();
        t_xfer();
        t_data();
        t_calc();
        t_untag();
        t_idle();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule